// File: doc/BRIEF.md
# Packed Word FIFO Data Path for a Card Host

This block carries block data between a 32-bit host register port and a byte-wide card data port. A 16-word circular FIFO sits between them. Software programs a block size in bytes and a block count. Writing the count starts a transfer of count × size bytes. In read mode, bytes offered by the card are assembled into 32-bit words and queued for the host. In write mode, words that the host has queued are split into bytes and offered to the card.

The block keeps three sticky status bits: a data-moved flag, a data interrupt and a block-boundary interrupt. The host clears them by writing ones. A debug register shows the live FIFO occupancy and a small state code. The state code changes to the data-mode value when a transfer runs to its end. The card side moves at most one byte per clock in each direction, with a valid/ready handshake. A read of the data register returns the FIFO head and pops it in the same cycle.

Top module: `sdp_datapath`

## Requirements
- R1: Host register selector codes are: 0 data, 1 configuration, 2 block size, 3 block count, 4 status, 5 debug. Other codes read as zero. After reset, every readable register reads zero, except debug, which reads 0x0000C60F. After reset, card_rx_ready and card_tx_valid are low.
- R2: A write to the block-count register loads the remaining-byte counter with the written count times the stored block size. The counter falls by one for each card byte moved, and no bytes move once it is zero.
- R3: In read mode (mode_rd high), card bytes are packed least-significant first. Byte n of a word lands at bits 8n+7:8n. The word is queued when its fourth byte arrives.
- R4: If the remaining count runs out part-way through a word, the partial word is queued anyway, with its unfilled upper bytes zero.
- R5: The FIFO holds 16 words. card_rx_ready is low while it is full. A host write to the data register while the FIFO is full is dropped.
- R6: A data-register read while the FIFO is empty returns zero and leaves the occupancy unchanged.
- R7: In write mode (mode_wr high, mode_rd low), each word popped is sent lowest byte first, one byte per handshake. Sending stops when the remaining count or the FIFO runs dry. Bytes still held when the count reaches zero are discarded.
- R8: Every word that the card path queues or pops sets status bit 0. It also sets status bit 8 when configuration bit 4 is set.
- R9: In write mode, status bit 9 is set when a sent byte completes a block, that is, when the remaining count becomes a multiple of the block size. This happens only when configuration bit 8 is set.
- R10: Writing the status register clears each of bits 0, 8 and 9 for which the written bit is one. A set event in the same cycle wins over the clear.
- R11: Debug bits 8:4 always read the FIFO occupancy. Debug bits 3:0 become 1 when a card byte brings the remaining count to zero.
- R12: A host write to the debug register stores bits 31:9 and 3:0. A low nibble of 0xF is stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Host register selector |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (pops on data) |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for the selected register |
| mode_rd | input | 1 | Card-to-host transfer mode |
| mode_wr | input | 1 | Host-to-card transfer mode |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_valid | input | 1 | Card byte offered |
| card_rx_ready | output | 1 | Block accepts the card byte |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_valid | output | 1 | Block offers a byte to the card |
| card_tx_ready | input | 1 | Card accepts the byte |

## Verification
The hardest state to reach is a FIFO held full while the card keeps offering bytes. In that state, a host write to the data register must be dropped and the card handshake must stall. The stimulus reaches it by streaming more bytes than 16 words hold and issuing no host reads. It then writes into the full FIFO and drains it, which opens room for the remaining bytes. Write-mode runs use a stalling ready pattern and a block size that is not a multiple of four. These runs expose held bytes that must be discarded and block interrupts that must fire only on block boundaries.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_DATA   = 3'd0,
    SEL_CFG    = 3'd1,
    SEL_SIZE   = 3'd2,
    SEL_COUNT  = 3'd3,
    SEL_STATUS = 3'd4,
    SEL_DEBUG  = 3'd5
  } sdp_sel_e;

  // configuration bits
  localparam int CFG_DATA_IE  = 4;
  localparam int CFG_BLOCK_IE = 8;

  // positions of the sticky bits in the status register
  localparam int STS_FLAG_BIT  = 0;
  localparam int STS_DATA_BIT  = 8;
  localparam int STS_BLOCK_BIT = 9;

  localparam logic [31:0] DBG_RESET      = 32'h0000_C60F;
  localparam logic [3:0]  DBG_STATE_DATA = 4'h1;
endpackage

// File: rtl/sdp_word_fifo.sv
module sdp_word_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_idx;
  logic [LW-1:0] len_q, len_d;
  logic          do_push, do_pop;

  assign full    = (len_q == LW'(DEPTH));
  assign empty   = (len_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign wr_idx  = rd_q + len_q[PW-1:0];
  assign head    = empty ? '0 : mem[rd_q];
  assign level   = len_q;

  always_comb begin
    rd_d  = rd_q;
    len_d = len_q;
    if (do_pop)  rd_d = rd_q + PW'(1);
    if (do_push && !do_pop) len_d = len_q + LW'(1);
    if (do_pop && !do_push) len_d = len_q - LW'(1);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      len_q <= '0;
    end else begin
      rd_q  <= rd_d;
      len_q <= len_d;
    end
  end
endmodule

// File: rtl/sdp_rx_packer.sv
module sdp_rx_packer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         take,
  input  logic         last,
  input  logic [7:0]   byte_in,
  output logic         push,
  output logic [W-1:0] push_word
);
  localparam int LANES = W / 8;
  localparam int NW    = $clog2(LANES);

  logic [W-1:0]  acc_q, acc_d;
  logic [NW-1:0] n_q, n_d;

  // the incoming byte goes into the lane picked by the byte index
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign push_word[8*g +: 8] = (n_q == NW'(g)) ? byte_in : acc_q[8*g +: 8];
  end

  assign push = take & ((n_q == NW'(LANES - 1)) | last);

  always_comb begin
    acc_d = acc_q;
    n_d   = n_q;
    if (clr) begin
      acc_d = '0;
      n_d   = '0;
    end else if (take) begin
      if (push) begin
        acc_d = '0;
        n_d   = '0;
      end else begin
        acc_d = push_word;
        n_d   = n_q + NW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      n_q   <= '0;
    end else begin
      acc_q <= acc_d;
      n_q   <= n_d;
    end
  end
endmodule

// File: rtl/sdp_tx_unpacker.sv
module sdp_tx_unpacker #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] head,
  input  logic         empty,
  input  logic         ready,
  input  logic         last,
  output logic         valid,
  output logic [7:0]   byte_out,
  output logic         pop
);
  localparam int LANES = W / 8;
  localparam int NW    = $clog2(LANES);

  logic [W-9:0]  hold_q, hold_d;
  logic [NW-1:0] left_q, left_d;
  logic          has, take;

  assign has      = (left_q != '0);
  assign valid    = en & (has | ~empty);
  assign byte_out = has ? hold_q[7:0] : head[7:0];
  assign take     = valid & ready;
  assign pop      = take & ~has;

  always_comb begin
    hold_d = hold_q;
    left_d = left_q;
    if (clr || (take && last)) begin
      left_d = '0;
    end else if (take) begin
      if (has) begin
        hold_d = hold_q >> 8;
        left_d = left_q - NW'(1);
      end else begin
        hold_d = head[W-1:8];
        left_d = NW'(LANES - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      left_q <= '0;
    end else begin
      hold_q <= hold_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/sdp_datapath.sv
module sdp_datapath
  import sdp_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int SIZE_W  = 10,
  parameter int COUNT_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_sel,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        mode_rd,
  input  logic        mode_wr,
  input  logic [7:0]  card_rx_data,
  input  logic        card_rx_valid,
  output logic        card_rx_ready,
  output logic [7:0]  card_tx_data,
  output logic        card_tx_valid,
  input  logic        card_tx_ready
);
  localparam int REM_W = SIZE_W + COUNT_W;
  localparam int LVL_W = $clog2(DEPTH) + 1;

  // registers
  logic [31:0]        cfg_q, cfg_d;
  logic [SIZE_W-1:0]  size_q, size_d;
  logic [COUNT_W-1:0] cnt_q, cnt_d;
  logic [REM_W-1:0]   rem_q, rem_d;
  logic [SIZE_W-1:0]  blk_q, blk_d;
  logic [2:0]         sts_q, sts_d;     // {block, data irq, flag}
  logic [31:9]        dbg_hi_q, dbg_hi_d;
  logic [3:0]         dbg_st_q, dbg_st_d;

  // host decode
  logic wr_data, rd_data, wr_cfg, wr_size, wr_cnt, wr_sts, wr_dbg;
  assign wr_data = reg_wr && (reg_sel == SEL_DATA);
  assign rd_data = reg_rd && (reg_sel == SEL_DATA);
  assign wr_cfg  = reg_wr && (reg_sel == SEL_CFG);
  assign wr_size = reg_wr && (reg_sel == SEL_SIZE);
  assign wr_cnt  = reg_wr && (reg_sel == SEL_COUNT);
  assign wr_sts  = reg_wr && (reg_sel == SEL_STATUS);
  assign wr_dbg  = reg_wr && (reg_sel == SEL_DEBUG);

  // data path
  logic              rem_nz, last, rx_take, tx_take, xfer, blk_fire;
  logic              path_push, path_pop;
  logic [WORD_W-1:0] pk_word, fifo_head, fifo_wdata;
  logic [LVL_W-1:0]  fifo_level;
  logic              fifo_full, fifo_empty, fifo_push, fifo_pop;

  assign rem_nz        = (rem_q != '0);
  assign last          = (rem_q == REM_W'(1));
  assign card_rx_ready = mode_rd & rem_nz & ~fifo_full;
  assign rx_take       = card_rx_ready & card_rx_valid;
  assign tx_take       = card_tx_valid & card_tx_ready;
  assign xfer          = rx_take | tx_take;
  assign blk_fire      = tx_take & (blk_q == SIZE_W'(1)) & cfg_q[CFG_BLOCK_IE];

  // the card path owns the FIFO write port whenever it pushes
  assign fifo_push  = path_push | wr_data;
  assign fifo_wdata = path_push ? pk_word : reg_wdata;
  assign fifo_pop   = path_pop | rd_data;

  sdp_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fifo_push),
    .push_data (fifo_wdata),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .level     (fifo_level),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  sdp_rx_packer #(.W(WORD_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (wr_cnt),
    .take      (rx_take),
    .last      (last),
    .byte_in   (card_rx_data),
    .push      (path_push),
    .push_word (pk_word)
  );

  sdp_tx_unpacker #(.W(WORD_W)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (wr_cnt),
    .en       (mode_wr & ~mode_rd & rem_nz),
    .head     (fifo_head),
    .empty    (fifo_empty),
    .ready    (card_tx_ready),
    .last     (last),
    .valid    (card_tx_valid),
    .byte_out (card_tx_data),
    .pop      (path_pop)
  );

  // next state
  always_comb begin
    cfg_d    = cfg_q;
    size_d   = size_q;
    cnt_d    = cnt_q;
    rem_d    = rem_q;
    blk_d    = blk_q;
    sts_d    = sts_q;
    dbg_hi_d = dbg_hi_q;
    dbg_st_d = dbg_st_q;

    if (xfer) rem_d = rem_q - REM_W'(1);
    if (tx_take) blk_d = (blk_q == SIZE_W'(1)) ? size_q : blk_q - SIZE_W'(1);

    if (wr_sts)
      sts_d = sts_q & ~{reg_wdata[STS_BLOCK_BIT], reg_wdata[STS_DATA_BIT],
                        reg_wdata[STS_FLAG_BIT]};
    if (path_push || path_pop) begin
      sts_d[0] = 1'b1;
      if (cfg_q[CFG_DATA_IE]) sts_d[1] = 1'b1;
    end
    if (blk_fire) sts_d[2] = 1'b1;

    if (wr_dbg) begin
      dbg_hi_d = reg_wdata[31:9];
      dbg_st_d = (reg_wdata[3:0] == 4'hF) ? 4'h0 : reg_wdata[3:0];
    end
    if (xfer && last && !wr_cnt) dbg_st_d = DBG_STATE_DATA;

    if (wr_cfg)  cfg_d  = reg_wdata;
    if (wr_size) size_d = reg_wdata[SIZE_W-1:0];
    if (wr_cnt) begin
      cnt_d = reg_wdata[COUNT_W-1:0];
      rem_d = REM_W'(reg_wdata[COUNT_W-1:0]) * REM_W'(size_q);
      blk_d = size_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      size_q   <= '0;
      cnt_q    <= '0;
      rem_q    <= '0;
      blk_q    <= '0;
      sts_q    <= '0;
      dbg_hi_q <= DBG_RESET[31:9];
      dbg_st_q <= DBG_RESET[3:0];
    end else begin
      cfg_q    <= cfg_d;
      size_q   <= size_d;
      cnt_q    <= cnt_d;
      rem_q    <= rem_d;
      blk_q    <= blk_d;
      sts_q    <= sts_d;
      dbg_hi_q <= dbg_hi_d;
      dbg_st_q <= dbg_st_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_DATA:   reg_rdata = fifo_head;
      SEL_CFG:    reg_rdata = cfg_q;
      SEL_SIZE:   reg_rdata = 32'(size_q);
      SEL_COUNT:  reg_rdata = 32'(cnt_q);
      SEL_STATUS: reg_rdata = {22'b0, sts_q[2], sts_q[1], 7'b0, sts_q[0]};
      SEL_DEBUG:  reg_rdata = {dbg_hi_q, 5'(fifo_level), dbg_st_q};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdp_datapath_chk.sv
module sdp_datapath_chk #(
  parameter int DEPTH = 16,
  parameter int REM_W = 19,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       reg_sel,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic             mode_rd,
  input logic             mode_wr,
  input logic             card_rx_ready,
  input logic             card_tx_valid,
  input logic [7:0]       card_tx_data,
  input logic             card_tx_ready,
  input logic [LVL_W-1:0] level,
  input logic [REM_W-1:0] rem,
  input logic             path_push,
  input logic             path_pop,
  input logic [2:0]       sts
);
  p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH)) |-> !card_rx_ready);

  p_level_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level == $past(level) || level == $past(level) + LVL_W'(1) ||
              level == $past(level) - LVL_W'(1)));

  p_idle_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rem == '0) |-> (!card_tx_valid && !card_rx_ready));

  p_rem_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel == 3'd3) |=>
      (rem == $past(rem) || rem == $past(rem) - REM_W'(1)));

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (card_tx_valid && !card_tx_ready && !reg_rd && !(reg_wr && reg_sel == 3'd3))
      |=> (!mode_wr || mode_rd || (card_tx_valid && $stable(card_tx_data))));

  p_flag_after_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (path_push || path_pop) |=> sts[0]);
endmodule

bind sdp_datapath sdp_datapath_chk #(.DEPTH(DEPTH), .REM_W(REM_W), .LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_sel       (reg_sel),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .mode_rd       (mode_rd),
  .mode_wr       (mode_wr),
  .card_rx_ready (card_rx_ready),
  .card_tx_valid (card_tx_valid),
  .card_tx_data  (card_tx_data),
  .card_tx_ready (card_tx_ready),
  .level         (fifo_level),
  .rem           (rem_q),
  .path_push     (path_push),
  .path_pop      (path_pop),
  .sts           (sts_q)
);

// File: tb/sdp_datapath_test.sv
`timescale 1ns/1ps
module sdp_datapath_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  reg_sel;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mode_rd, mode_wr;
  logic [7:0]  card_rx_data, card_tx_data;
  logic        card_rx_valid, card_rx_ready, card_tx_valid, card_tx_ready;

  always #4 clk = ~clk;

  sdp_datapath uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_rd(mode_rd), .mode_wr(mode_wr),
    .card_rx_data(card_rx_data), .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
    .card_tx_data(card_tx_data), .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] m_q[$];
  logic [31:0] m_cfg, m_sts, m_dbg, m_pk, m_uw;
  int          m_size, m_cnt, m_rem, m_blk, m_pn, m_un;
  int          next_byte;
  logic [7:0]  got[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_rx_ready();
    return mode_rd && m_rem != 0 && m_q.size() < DEPTH;
  endfunction
  function automatic bit m_tx_valid();
    return mode_wr && !mode_rd && m_rem != 0 && (m_un > 0 || m_q.size() > 0);
  endfunction
  function automatic logic [7:0] m_tx_data();
    return (m_un > 0) ? m_uw[7:0] : m_q[0][7:0];
  endfunction
  function automatic logic [31:0] m_rdata(input logic [2:0] s);
    case (s)
      3'd0: return (m_q.size() > 0) ? m_q[0] : 32'h0;
      3'd1: return m_cfg;
      3'd2: return 32'(m_size);
      3'd3: return 32'(m_cnt);
      3'd4: return m_sts;
      3'd5: return {m_dbg[31:9], 5'(m_q.size()), m_dbg[3:0]};
      default: return 32'h0;
    endcase
  endfunction
  function automatic string sel_tag(input logic [2:0] s);
    case (s)
      3'd0: return "R3 data";
      3'd3: return "R2 count";
      3'd4: return "R8 status";
      3'd5: return "R11 debug";
      default: return "R1 register";
    endcase
  endfunction

  task automatic model_step();
    bit full0 = (m_q.size() >= DEPTH);
    bit rx_t = m_rx_ready() && card_rx_valid;
    bit tx_t = m_tx_valid() && card_tx_ready;
    bit ppush = 0, ppop = 0, zero_hit = 0;
    logic [31:0] pw = 0, w, setb = 0;
    if (rx_t) begin
      w = m_pk | (32'(card_rx_data) << (8 * m_pn));
      if (m_pn == 3 || m_rem == 1) begin ppush = 1; pw = w; m_pk = 0; m_pn = 0; end
      else begin m_pk = w; m_pn++; end
    end
    if (tx_t) begin
      if (m_un == 0) begin ppop = 1; m_uw = m_q[0] >> 8; m_un = 3; end
      else begin m_uw = m_uw >> 8; m_un--; end
      if (m_blk == 1) begin
        if (m_cfg[8]) setb[9] = 1'b1;
        m_blk = m_size;
      end else m_blk--;
    end
    if (rx_t || tx_t) begin
      m_rem--;
      if (m_rem == 0) begin m_un = 0; zero_hit = 1; end
    end
    if (ppush || ppop) begin
      setb[0] = 1'b1;
      if (m_cfg[4]) setb[8] = 1'b1;
    end
    if (ppop || (reg_rd && reg_sel == 3'd0 && m_q.size() > 0)) void'(m_q.pop_front());
    if (ppush) begin
      if (!full0) m_q.push_back(pw);
    end else if (reg_wr && reg_sel == 3'd0 && !full0) m_q.push_back(reg_wdata);
    if (reg_wr && reg_sel == 3'd4) m_sts = m_sts & ~(reg_wdata & 32'h301);
    m_sts = m_sts | setb;
    if (reg_wr && reg_sel == 3'd5)
      m_dbg = {reg_wdata[31:4], (reg_wdata[3:0] == 4'hF) ? 4'h0 : reg_wdata[3:0]};
    if (zero_hit && !(reg_wr && reg_sel == 3'd3)) m_dbg[3:0] = 4'h1;
    if (reg_wr && reg_sel == 3'd1) m_cfg = reg_wdata;
    if (reg_wr && reg_sel == 3'd2) m_size = int'(reg_wdata[9:0]);
    if (reg_wr && reg_sel == 3'd3) begin
      m_cnt = int'(reg_wdata[8:0]);
      m_rem = m_cnt * m_size;
      m_blk = m_size;
      m_pk = 0; m_pn = 0; m_un = 0;
    end
  endtask

  // compare every output against the model, then advance one clock
  task automatic tick();
    #1;
    chk(card_rx_ready === m_rx_ready(), "R5 rx_ready", 32'(card_rx_ready), 32'(m_rx_ready()));
    chk(card_tx_valid === m_tx_valid(), "R7 tx_valid", 32'(card_tx_valid), 32'(m_tx_valid()));
    if (m_tx_valid())
      chk(card_tx_data === m_tx_data(), "R7 tx_data", 32'(card_tx_data), 32'(m_tx_data()));
    chk(reg_rdata === m_rdata(reg_sel), sel_tag(reg_sel), reg_rdata, m_rdata(reg_sel));
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, input logic [31:0] exp, input string tag, input bit pop);
    reg_sel = s; reg_rd = pop;
    #1 chk(reg_rdata === exp, tag, reg_rdata, exp);
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic feed(input int n, input int cap);
    int sent = 0;
    for (int c = 0; c < cap && sent < n; c++) begin
      bit acc;
      card_rx_valid = 1'b1;
      card_rx_data  = 8'(next_byte);
      acc = m_rx_ready();
      tick();
      if (acc) begin next_byte++; sent++; end
    end
    card_rx_valid = 1'b0;
  endtask

  task automatic drain(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      card_tx_ready = (c % 3 != 1);
      if (m_tx_valid() && card_tx_ready) got.push_back(card_tx_data);
      tick();
    end
    card_tx_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_sel = 3'd0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    mode_rd = 0; mode_wr = 0; card_rx_data = 0; card_rx_valid = 0; card_tx_ready = 0;
    m_cfg = 0; m_sts = 0; m_dbg = 32'h0000C60F; m_pk = 0; m_uw = 0;
    m_size = 0; m_cnt = 0; m_rem = 0; m_blk = 0; m_pn = 0; m_un = 0; next_byte = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1 chk(card_rx_ready === 1'b0 && card_tx_valid === 1'b0, "R1 handshakes idle",
           32'({card_rx_ready, card_tx_valid}), 32'h0);
    rd_reg(3'd1, 32'h0, "R1 config reset", 0);
    rd_reg(3'd4, 32'h0, "R1 status reset", 0);
    rd_reg(3'd5, 32'h0000C60F, "R1 debug reset", 0);
    rd_reg(3'd7, 32'h0, "R1 unused selector", 0);

    // read mode, 6 bytes: packing and partial word (R2 R3 R4)
    mode_rd = 1;
    wr_reg(3'd2, 6);
    wr_reg(3'd3, 1);
    reg_sel = 3'd5;
    feed(8, 12);
    #1 chk(next_byte == 7, "R2 bytes taken", 32'(next_byte - 1), 32'd6);
    rd_reg(3'd5, 32'h0000C621, "R11 debug level and state", 0);
    rd_reg(3'd4, 32'h00000001, "R8 flag only", 0);
    rd_reg(3'd0, 32'h04030201, "R3 packed order", 1);
    rd_reg(3'd0, 32'h00000605, "R4 partial word", 1);
    rd_reg(3'd0, 32'h0, "R6 empty read", 1);
    rd_reg(3'd5, 32'h0000C601, "R6 level unchanged", 0);

    // full FIFO (R5), data interrupt (R8), clear (R10)
    wr_reg(3'd1, 32'h10);
    wr_reg(3'd4, 32'hFFFFFFFF);
    rd_reg(3'd4, 32'h0, "R10 clear all", 0);
    wr_reg(3'd2, 4);
    wr_reg(3'd3, 20);
    next_byte = 8'h20;
    reg_sel = 3'd5;
    feed(80, 75);
    #1 chk(card_rx_ready === 1'b0, "R5 stall when full", 32'(card_rx_ready), 32'h0);
    rd_reg(3'd5, 32'h0000C701, "R5 level sixteen", 0);
    wr_reg(3'd0, 32'hDEADBEEF);
    rd_reg(3'd5, 32'h0000C701, "R5 write dropped", 0);
    rd_reg(3'd0, 32'h23222120, "R3 first word", 1);
    for (int i = 1; i < 16; i++) rd_reg(3'd0, m_rdata(3'd0), "R5 drain", 1);
    reg_sel = 3'd4;
    feed(16, 30);
    rd_reg(3'd0, 32'h63626160, "R3 word after stall", 1);
    for (int i = 1; i < 4; i++) rd_reg(3'd0, m_rdata(3'd0), "R3 tail", 1);
    rd_reg(3'd4, 32'h00000101, "R8 data interrupt", 0);
    wr_reg(3'd4, 32'h100);
    rd_reg(3'd4, 32'h00000001, "R10 partial clear", 0);

    // write mode, three 4-byte blocks (R7 R9)
    mode_rd = 0; mode_wr = 1;
    wr_reg(3'd1, 32'h110);
    wr_reg(3'd4, 32'hFFFFFFFF);
    wr_reg(3'd2, 4);
    wr_reg(3'd3, 3);
    wr_reg(3'd0, 32'hA3A2A1A0);
    wr_reg(3'd0, 32'hB3B2B1B0);
    wr_reg(3'd0, 32'hC3C2C1C0);
    reg_sel = 3'd4;
    got.delete();
    drain(30);
    #1 chk(got.size() == 12, "R7 byte count", 32'(got.size()), 32'd12);
    for (int i = 0; i < 12 && i < got.size(); i++)
      chk(got[i] == 8'(8'hA0 + 16 * (i / 4) + (i % 4)), "R7 byte order",
          32'(got[i]), 32'(8'hA0 + 16 * (i / 4) + (i % 4)));
    rd_reg(3'd4, 32'h00000301, "R9 block interrupt", 0);

    // write mode, 5-byte block: leftover bytes discarded (R7 R9 R11)
    wr_reg(3'd1, 32'h100);
    wr_reg(3'd4, 32'hFFFFFFFF);
    wr_reg(3'd2, 5);
    wr_reg(3'd3, 1);
    wr_reg(3'd0, 32'h14131211);
    wr_reg(3'd0, 32'h24232221);
    reg_sel = 3'd4;
    got.delete();
    drain(15);
    #1 chk(got.size() == 5 && got[4] == 8'h21, "R7 stop at count", 32'(got.size()), 32'd5);
    rd_reg(3'd4, 32'h00000201, "R9 odd block size", 0);
    rd_reg(3'd5, 32'h0000C601, "R11 state after write", 0);
    wr_reg(3'd0, 32'h55);
    #1 chk(card_tx_valid === 1'b0, "R7 idle at zero count", 32'(card_tx_valid), 32'h0);
    rd_reg(3'd0, 32'h55, "R7 word left queued", 1);

    // debug write nibble rule (R12)
    wr_reg(3'd5, 32'h1234567F);
    rd_reg(3'd5, 32'h12345600, "R12 nibble F stored as zero", 0);
    wr_reg(3'd5, 32'h000000A3);
    rd_reg(3'd5, 32'h00000003, "R12 plain nibble kept", 0);

    finish_run();
  end
endmodule